// File: doc/BRIEF.md
# Two-Level I/O Address Translator

This block sits between DMA-capable devices and memory. It turns a device bus address into a physical address. The lookup uses a first-level table held on chip in 64 configuration registers. Each first-level slot covers 32 MiB of bus space. It either maps that whole region directly as a big page, or points at a second-level table in memory. A second-level table holds 8K four-byte entries, one for each 4 KiB page.

A four-entry translation cache keeps recent second-level results, so a repeated page is answered without a memory read. Software programs the block through a small register port. That port holds:
- the enable bit;
- the window size;
- the first-level slots;
- an invalidate register that drops cached translations for one 16 KiB group of bus addresses.

Top module: `io_addr_xlat`

## Requirements
- R1: The low 12 bits of every non-faulting response equal the low 12 bits of the request. The page number above them comes from the selected mapping.
- R2: While bit 8 of the control register (offset 0x000) is clear, each accepted request is answered on the next cycle. The response carries `rsp_addr` equal to the request address, zero-extended, with no fault, no cached flag and no memory read.
- R3: Bits [1:0] of the window register (offset 0x004) select the window: 0 accepts addresses below 2^28, 1 below 2^31 and 3 below 2^37. Value 2 accepts none. An address outside the window faults with no memory read. The first-level slot is always picked by address bits [30:25], so with the largest window, higher addresses reuse the same 64 slots.
- R4: A first-level slot (offset 0x100 + 4*slot) is valid when bit 30 is set. An invalid slot gives a fault on the next cycle with no memory read.
- R5: For a valid slot with bit 31 clear, a cache miss issues exactly one read. The read address is (slot[29:0] << 12) + 4 * address[24:12]. The response follows the read data. A returned word with bit 31 set translates to page number word[29:0], with the cached flag taken from word bit 30.
- R6: A returned second-level word with bit 31 clear gives a fault and is not cached, so repeating the request reads memory again.
- R7: A slot with bits 31 and 30 both set is a big page, answered on the next cycle with no read. The physical address is {slot[29:13], address[24:0]}, the cached flag is slot bit 1 and the priority flag is slot bit 0.
- R8: A request whose page is held in the translation cache is answered on the next cycle with no memory read.
- R9: The cache holds four pages and replaces them in round-robin order of filling.
- R10: A write of value V to the invalidate register (offset 0x008) drops every cached page whose bus address shifted right by 14 equals V. Other cached pages stay.
- R11: Register reads return the control enable bit at bit 8, the window code at bits [1:0] and each first-level slot in full. The invalidate register reads as zero.
- R12: `req_ready` is low from the cycle after a miss is accepted until its response. No response appears while a read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | BUS_AW | Device bus address |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Translation failed |
| rsp_addr | output | PHYS_AW | Physical address |
| rsp_cached | output | 1 | Mapping marked cacheable |
| rsp_prio | output | 1 | Big-page priority flag |
| mem_req | output | 1 | One-cycle second-level read request |
| mem_addr | output | PHYS_AW | Second-level entry address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Second-level entry word |

## Verification
The assertions assume the memory side behaves in a fixed way:
- it answers each read exactly once;
- it answers no earlier than the cycle after `mem_req`;
- it never raises `mem_rvalid` unprompted.

The bench memory model meets this by answering with a fixed two-cycle delay. The assertions also assume requests are only offered while `req_ready` is high. The bench issues one request at a time and waits for its response before the next.

// File: rtl/io_addr_xlat.sv
module io_addr_xlat #(
  parameter int BUS_AW  = 40,
  parameter int PHYS_AW = 42,
  parameter int CFG_AW  = 10,
  parameter int L1_N    = 64,
  parameter int TLB_N   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [BUS_AW-1:0]  req_addr,
  output logic               rsp_valid,
  output logic               rsp_fault,
  output logic [PHYS_AW-1:0] rsp_addr,
  output logic               rsp_cached,
  output logic               rsp_prio,
  output logic               mem_req,
  output logic [PHYS_AW-1:0] mem_addr,
  input  logic               mem_rvalid,
  input  logic [31:0]        mem_rdata
);
  localparam int PN_W  = PHYS_AW - 12;
  localparam int VPN_W = BUS_AW - 12;
  localparam int L1_IW = $clog2(L1_N);
  localparam int TI_W  = $clog2(TLB_N);
  localparam logic [CFG_AW-1:0] A_CTRL  = CFG_AW'('h000);
  localparam logic [CFG_AW-1:0] A_WIN   = CFG_AW'('h004);
  localparam logic [CFG_AW-1:0] A_FLUSH = CFG_AW'('h008);
  localparam logic [CFG_AW-1:0] A_L1LO  = CFG_AW'('h100);
  localparam logic [CFG_AW-1:0] A_L1HI  = CFG_AW'('h100 + 4 * L1_N);

  logic              en_q;
  logic [1:0]        win_q;
  logic [31:0]       l1_q [L1_N];
  logic [TLB_N-1:0]  t_v;
  logic [VPN_W-1:0]  t_vpn [TLB_N];
  logic [PN_W-1:0]   t_pn [TLB_N];
  logic [TLB_N-1:0]  t_c;
  logic [TI_W-1:0]   rr_q;
  logic              busy_q;
  logic [VPN_W-1:0]  p_vpn;
  logic [11:0]       p_off;

  wire l1_sel = (cfg_addr >= A_L1LO) && (cfg_addr < A_L1HI);
  wire [L1_IW-1:0] cfg_l1 = cfg_addr[2 +: L1_IW];
  wire flush_wr = cfg_wr && (cfg_addr == A_FLUSH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      win_q <= 2'd0;
      for (int i = 0; i < L1_N; i++) l1_q[i] <= '0;
    end else if (cfg_wr) begin
      if (cfg_addr == A_CTRL) en_q <= cfg_wdata[8];
      if (cfg_addr == A_WIN)  win_q <= cfg_wdata[1:0];
      if (l1_sel) l1_q[cfg_l1] <= cfg_wdata;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == A_CTRL) cfg_rdata[8] = en_q;
    else if (cfg_addr == A_WIN) cfg_rdata[1:0] = win_q;
    else if (l1_sel) cfg_rdata = l1_q[cfg_l1];
  end

  assign req_ready = !busy_q;

  wire [VPN_W-1:0] req_vpn = req_addr[BUS_AW-1:12];
  wire [31:0]      l1e     = l1_q[req_addr[25 +: L1_IW]];

  logic in_win;
  always_comb begin
    case (win_q)
      2'd0:    in_win = (req_addr >> 28) == '0;
      2'd1:    in_win = (req_addr >> 31) == '0;
      2'd3:    in_win = (req_addr >> 37) == '0;
      default: in_win = 1'b0;
    endcase
  end

  logic            hit, hit_c;
  logic [PN_W-1:0] hit_pn;
  always_comb begin
    hit = 1'b0; hit_c = 1'b0; hit_pn = '0;
    for (int k = 0; k < TLB_N; k++)
      if (t_v[k] && t_vpn[k] == req_vpn) begin
        hit = 1'b1; hit_c = t_c[k]; hit_pn = t_pn[k];
      end
  end

  wire [PHYS_AW-1:0] l2_addr = {l1e[PN_W-1:0], 12'b0} + PHYS_AW'({req_addr[24:12], 2'b00});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; rr_q <= '0; t_v <= '0; t_c <= '0;
      p_vpn <= '0; p_off <= '0;
      for (int k = 0; k < TLB_N; k++) begin t_vpn[k] <= '0; t_pn[k] <= '0; end
      rsp_valid <= 1'b0; rsp_fault <= 1'b0; rsp_addr <= '0;
      rsp_cached <= 1'b0; rsp_prio <= 1'b0;
      mem_req <= 1'b0; mem_addr <= '0;
    end else begin
      rsp_valid <= 1'b0; rsp_fault <= 1'b0; rsp_cached <= 1'b0;
      rsp_prio <= 1'b0; mem_req <= 1'b0;
      if (flush_wr)
        for (int k = 0; k < TLB_N; k++)
          if (32'(t_vpn[k] >> 2) == cfg_wdata) t_v[k] <= 1'b0;
      if (!busy_q && req_valid) begin
        if (!en_q) begin
          rsp_valid <= 1'b1;
          rsp_addr  <= PHYS_AW'(req_addr);
        end else if (!in_win || !l1e[30]) begin
          rsp_valid <= 1'b1;
          rsp_fault <= 1'b1;
        end else if (l1e[31]) begin
          rsp_valid  <= 1'b1;
          rsp_addr   <= {l1e[PN_W-1:13], req_addr[24:0]};
          rsp_cached <= l1e[1];
          rsp_prio   <= l1e[0];
        end else if (hit) begin
          rsp_valid  <= 1'b1;
          rsp_addr   <= {hit_pn, req_addr[11:0]};
          rsp_cached <= hit_c;
        end else begin
          busy_q   <= 1'b1;
          mem_req  <= 1'b1;
          mem_addr <= l2_addr;
          p_vpn    <= req_vpn;
          p_off    <= req_addr[11:0];
        end
      end else if (busy_q && mem_rvalid) begin
        busy_q    <= 1'b0;
        rsp_valid <= 1'b1;
        if (mem_rdata[31]) begin
          rsp_addr    <= {mem_rdata[PN_W-1:0], p_off};
          rsp_cached  <= mem_rdata[30];
          t_v[rr_q]   <= 1'b1;
          t_vpn[rr_q] <= p_vpn;
          t_pn[rr_q]  <= mem_rdata[PN_W-1:0];
          t_c[rr_q]   <= mem_rdata[30];
          rr_q        <= rr_q + 1'b1;
        end else begin
          rsp_fault <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/io_addr_xlat_chk.sv
module io_addr_xlat_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [11:0] req_off,
  input logic        rsp_valid,
  input logic        rsp_fault,
  input logic [11:0] rsp_off,
  input logic        rsp_cached,
  input logic        mem_req,
  input logic        mem_rvalid
);
  logic        outst;
  logic [11:0] off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outst <= 1'b0;
      off_q <= '0;
    end else begin
      if (mem_rvalid) outst <= 1'b0;
      else if (mem_req) outst <= 1'b1;
      if (req_valid && req_ready) off_q <= req_off;
    end
  end

  AST_ACCEPT_ACTS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid != mem_req); // R8
  AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    outst |-> !mem_req); // R5
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_off == off_q); // R1
  AST_FAULT_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_valid && !rsp_cached); // R6
  AST_BUSY_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    outst |-> !req_ready && !rsp_valid); // R12
endmodule

bind io_addr_xlat io_addr_xlat_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_off(req_addr[11:0]), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
  .rsp_off(rsp_addr[11:0]), .rsp_cached(rsp_cached), .mem_req(mem_req),
  .mem_rvalid(mem_rvalid)
);

// File: tb/io_addr_xlat_tb.sv
`timescale 1ns/1ps
module io_addr_xlat_tb;
  localparam int BUS_AW = 40, PHYS_AW = 42, CFG_AW = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [CFG_AW-1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic req_valid = 1'b0, req_ready;
  logic [BUS_AW-1:0] req_addr = '0;
  logic rsp_valid, rsp_fault, rsp_cached, rsp_prio, mem_req;
  logic [PHYS_AW-1:0] rsp_addr, mem_addr;
  logic mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0, errors = 0, nreads = 0, pend_cnt = 0;
  logic [PHYS_AW-1:0] pend_addr = '0;

  io_addr_xlat u_dut (.*);

  always #2 clk = ~clk;

  function automatic logic [31:0] l2_word(input logic [PHYS_AW-1:0] a);
    if (a[6:2] == 5'h1F) return 32'h0;
    return {1'b1, a[7], a[31:2] ^ 30'h2AAAAAAA};
  endfunction

  function automatic logic [29:0] l1pn(input int i);
    return 30'h100 + 30'(i * 8);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (pend_cnt > 0) begin
        pend_cnt--;
        if (pend_cnt == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata = l2_word(pend_addr);
        end
      end
      if (mem_req) begin
        pend_addr = mem_addr;
        pend_cnt = 2;
        nreads++;
      end
    end
  end

  task automatic cfg_write(input logic [CFG_AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_check(input logic [CFG_AW-1:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    cfg_addr = a;
    #1;
    chk(cfg_rdata == e, tag, 64'(cfg_rdata), 64'(e));
  endtask

  task automatic xreq(input logic [BUS_AW-1:0] a, input bit ef, input logic [PHYS_AW-1:0] ea,
                      input bit ec, input bit ep, input int er, input bit one_cyc, input string tag);
    int r0, cyc;
    r0 = nreads;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    while (!rsp_valid && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
    chk(rsp_valid, {tag, " response"}, 64'(rsp_valid), 64'(1));
    chk(rsp_fault == ef, {tag, " fault"}, 64'(rsp_fault), 64'(ef));
    if (!ef) begin
      chk(rsp_addr == ea, {tag, " addr"}, 64'(rsp_addr), 64'(ea));
      chk(rsp_cached == ec, {tag, " cached"}, 64'(rsp_cached), 64'(ec));
      chk(rsp_prio == ep, {tag, " prio"}, 64'(rsp_prio), 64'(ep));
    end
    chk(nreads - r0 == er, {tag, " reads"}, 64'(nreads - r0), 64'(er));
    if (one_cyc) chk(cyc == 1, {tag, " latency"}, 64'(cyc), 64'(1));
  endtask

  task automatic go(input logic [8:0] hi, input int i, input logic [12:0] idx,
                    input logic [11:0] off, input int er, input string tag);
    logic [31:0] w;
    w = l2_word({l1pn(i), 12'b0} + PHYS_AW'({idx, 2'b00}));
    xreq({hi, 6'(i), idx, off}, !w[31], {w[29:0], off}, w[30], 1'b0, er, er == 0, tag);
  endtask

  localparam logic [31:0] BIG = 32'hC000_0000 | 32'h0001_E000 | 32'h3;

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [BUS_AW-1:0] pa;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "reset R12 ready", 64'(req_ready), 64'(1));
    chk(rsp_valid == 1'b0, "reset rsp_valid", 64'(rsp_valid), 64'(0));
    chk(mem_req == 1'b0, "reset mem_req", 64'(mem_req), 64'(0));
    cfg_check(10'h000, 32'h0, "reset R11 ctrl");

    // R2 pass-through while disabled
    xreq(40'h00_1234_5678, 0, 42'h00_1234_5678, 0, 0, 0, 1, "R2 low");
    xreq(40'hFF_FFFF_FFFF, 0, 42'h00FF_FFFF_FFFF, 0, 0, 0, 1, "R2 high");

    for (int i = 0; i < 64; i++) begin
      if (i == 5) cfg_write(10'(12'h100 + i * 4), 32'h0);
      else if (i == 7) cfg_write(10'(12'h100 + i * 4), BIG);
      else cfg_write(10'(12'h100 + i * 4), 32'h4000_0000 | 32'(l1pn(i)));
    end
    cfg_write(10'h004, 32'h1);
    cfg_write(10'h000, 32'h100);
    cfg_check(10'h000, 32'h100, "R11 ctrl");
    cfg_check(10'h004, 32'h1, "R11 window");
    cfg_check(10'h11C, BIG, "R11 slot7");
    cfg_check(10'h114, 32'h0, "R11 slot5");
    cfg_check(10'h008, 32'h0, "R11 flush reads zero");

    // R1 R5 R6 R8 R4 R7 sweep of all first-level slots
    for (int i = 0; i < 64; i++) begin
      logic [12:0] idx;
      idx = 13'(i * 129);
      if (i == 5) begin
        xreq({9'b0, 6'(i), idx, 12'hABC}, 1, '0, 0, 0, 0, 1, "R4 invalid slot");
        xreq({9'b0, 6'(i), idx, 12'h123}, 1, '0, 0, 0, 0, 1, "R4 invalid slot again");
      end else if (i == 7) begin
        xreq({9'b0, 6'(i), idx, 12'hABC}, 0, {17'hF, idx, 12'hABC}, 1, 1, 0, 1, "R7 big page");
      end else begin
        go(9'b0, i, idx, 12'hABC, 1, "R5 R1 miss");
        go(9'b0, i, idx, 12'h123, (i % 32 == 31) ? 1 : 0, "R8 R6 repeat");
      end
    end

    // R9 round-robin replacement
    go(9'b0, 10, 13'd100, 12'h010, 1, "R9 fill A");
    go(9'b0, 10, 13'd101, 12'h020, 1, "R9 fill B");
    go(9'b0, 10, 13'd102, 12'h030, 1, "R9 fill C");
    go(9'b0, 10, 13'd103, 12'h040, 1, "R9 fill D");
    go(9'b0, 10, 13'd100, 12'h050, 0, "R9 A hit");
    go(9'b0, 10, 13'd104, 12'h060, 1, "R9 fill E");
    go(9'b0, 10, 13'd100, 12'h070, 1, "R9 A evicted");
    go(9'b0, 10, 13'd101, 12'h080, 1, "R9 B evicted");
    go(9'b0, 10, 13'd103, 12'h090, 0, "R9 D kept");
    go(9'b0, 10, 13'd104, 12'h0A0, 0, "R9 E kept");

    // R10 invalidate by 16 KiB group
    go(9'b0, 12, 13'd200, 12'h001, 1, "R10 fill P");
    go(9'b0, 12, 13'd201, 12'h002, 1, "R10 fill P1");
    go(9'b0, 12, 13'd204, 12'h003, 1, "R10 fill Q");
    go(9'b0, 12, 13'd200, 12'h004, 0, "R10 P hit");
    pa = {9'b0, 6'd12, 13'd200, 12'h000};
    cfg_write(10'h008, 32'(pa >> 14));
    go(9'b0, 12, 13'd204, 12'h005, 0, "R10 Q kept");
    go(9'b0, 12, 13'd200, 12'h006, 1, "R10 P dropped");
    go(9'b0, 12, 13'd201, 12'h007, 1, "R10 P1 dropped");

    // R3 window sizes
    go(9'b0, 32, 13'd0, 12'h111, 1, "R3 2G inside");
    xreq(40'h00_8000_0000, 1, '0, 0, 0, 0, 1, "R3 2G outside");
    cfg_write(10'h004, 32'h3);
    go(9'h001, 0, 13'd0, 12'h222, 1, "R3 128G alias bit31");
    go(9'h020, 0, 13'd0, 12'h333, 1, "R3 128G alias bit36");
    xreq(40'h20_0000_0000, 1, '0, 0, 0, 0, 1, "R3 128G outside");
    cfg_write(10'h004, 32'h0);
    xreq(40'h00_0FFF_F444, 0, {17'hF, 25'h1FF_F444}, 1, 1, 0, 1, "R3 R7 256M inside");
    xreq(40'h00_1000_0000, 1, '0, 0, 0, 0, 1, "R3 256M outside");
    cfg_write(10'h004, 32'h2);
    xreq(40'h00_0000_0000, 1, '0, 0, 0, 0, 1, "R3 reserved code");

    cfg_write(10'h000, 32'h0);
    xreq(40'h00_8000_1234, 0, 42'h00_8000_1234, 0, 0, 0, 1, "R2 disabled again");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule